// File: doc/BRIEF.md
# Multi-Lane Serial Flash Bus Monitor

A passive observer for a serial flash bus. It samples the chip select, the serial clock and four bidirectional data lines with a faster system clock. It follows each transaction through its phases: command, address, mode, dummy and data. It reports the command byte, the 24-bit address and every data byte, each with a one-cycle strobe. The block never drives the bus.

The number of data lines in use changes per phase and per command. Commands always travel on one line. The address travels on one or four lines, and data travels on one, two or four lines, all chosen by the command byte. A quad-address read can carry a mode byte that puts the flash into a continuous-read mode. While that mode is active, the next transaction begins directly with the address and carries no command byte, and the monitor tracks this state itself.

A trigger output pulses when a transaction carries a selected command byte and a selected address. It can be used to start a capture. Bytes arrive most significant bit first. When several lines are in use, the highest-numbered line carries the highest bit of each group.

Top module: `fsf_bus_monitor`

States: `ST_IDLE` (chip select high), `ST_CMD`, `ST_ADDR`, `ST_MODE`, `ST_DUMMY`, `ST_DATA`, `ST_SKIP`. Transitions:
- Any state goes to `ST_IDLE` when chip select is high.
- `ST_IDLE` goes to `ST_CMD` on chip select low, or to `ST_ADDR` if continuous mode is active.
- `ST_CMD` goes to `ST_ADDR` after a known command byte, or to `ST_SKIP` after any other command byte.
- `ST_ADDR` goes to `ST_MODE` after the third address byte of command EBh, or to `ST_DUMMY` after the third address byte of any other command.
- `ST_MODE` goes to `ST_DUMMY` after the mode byte.
- `ST_DUMMY` goes to `ST_DATA` after the last dummy clock.
- `ST_DATA` and `ST_SKIP` hold until chip select rises.

## Requirements
- R1: After reset, `op_valid`, `addr_valid`, `data_valid`, `trig_pulse` and `cont_active` are all 0.
- R2: The first 8 rising edges of `sck` after `cs_n` goes low carry the command byte on `io[0]`, most significant bit first. One `clk` cycle after the eighth edge is sampled, `op_valid` pulses and `op_byte` holds the byte.
- R3: Three address bytes follow the command, most significant byte and bit first, and `addr_valid` pulses with `addr` after the last one. For command EBh each address byte takes 2 clocks on `io[3:0]`, with `io[3]` carrying the highest bit. For commands 0Bh, 3Bh and 6Bh each address byte takes 8 clocks on `io[0]`.
- R4: Data bytes are taken from the lines chosen by the command: 0Bh uses `io[1]` with 8 clocks per byte, 3Bh uses `io[1:0]` (`io[1]` high) with 4 clocks per byte, and 6Bh and EBh use `io[3:0]` with 2 clocks per byte. Each byte pulses `data_valid` with `data_byte`.
- R5: The clocks between the address and the data are skipped and never reported as data. For 0Bh, 3Bh and 6Bh this is 8 dummy clocks. For EBh it is a 2-clock quad mode byte followed by 4 dummy clocks.
- R6: At the end of an EBh mode byte, `cont_active` becomes 1 if the mode byte's upper nibble is Ah, and becomes 0 otherwise. While `cs_n` stays high it does not change.
- R7: A transaction that begins while `cont_active` is 1 is decoded as EBh from its first clock, starting with the quad address. It produces no `op_valid`.
- R8: `trig_pulse` pulses in the same cycle as `addr_valid` only if a command byte was received in this transaction, that byte equals `trig_op`, and the address equals `trig_addr`.
- R9: `cs_n` going high ends the transaction in any phase and discards any partial byte. The next transaction is decoded from its first bit.
- R10: Any command byte other than 0Bh, 3Bh, 6Bh and EBh is reported through `op_valid`. The rest of that transaction produces no address or data strobe.
- R11: Each strobe (`op_valid`, `addr_valid`, `data_valid`) is high for exactly one `clk` cycle per decoded field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, at least twice the `sck` rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Observed bus chip select, active low |
| sck | input | 1 | Observed bus clock; data is taken on its rising edge |
| io | input | 4 | Observed data lines |
| trig_op | input | 8 | Command byte to trigger on |
| trig_addr | input | 24 | Address to trigger on |
| op_valid | output | 1 | One-cycle strobe: command byte decoded |
| op_byte | output | 8 | Last decoded command byte |
| addr_valid | output | 1 | One-cycle strobe: address decoded |
| addr | output | 24 | Last decoded address |
| data_valid | output | 1 | One-cycle strobe: data byte decoded |
| data_byte | output | 8 | Last decoded data byte |
| trig_pulse | output | 1 | One-cycle trigger on matching command and address |
| cont_active | output | 1 | Continuous-read mode is in effect |

## Verification
The trigger comparison and the address strobe fall in the same cycle. The trigger is raised by the same final address edge that completes `addr`. The bench sends matching, near-miss and opcode-less addresses, and counts how often `trig_pulse` and `addr_valid` were seen together at the same sampling instant. A trigger is judged correct only if it coincides with the address strobe, and only when the command byte was present and matched.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DUMMY,
        ST_DATA,
        ST_SKIP
    } fsf_state_e;

    typedef enum logic [1:0] {
        LN_ONE,
        LN_TWO,
        LN_FOUR
    } fsf_lanes_e;

    localparam logic [7:0] OP_FAST_SINGLE = 8'h0B;
    localparam logic [7:0] OP_DUAL_OUT    = 8'h3B;
    localparam logic [7:0] OP_QUAD_OUT    = 8'h6B;
    localparam logic [7:0] OP_QUAD_IO     = 8'hEB;

    function automatic logic is_read_op(input logic [7:0] op);
        return (op == OP_FAST_SINGLE) || (op == OP_DUAL_OUT) ||
               (op == OP_QUAD_OUT)    || (op == OP_QUAD_IO);
    endfunction

endpackage

// File: rtl/fsf_edge.sv
module fsf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic sck_rise
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign sck_rise = sck & ~sck_q;
endmodule

// File: rtl/fsf_shift.sv
module fsf_shift
    import fsf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           shift_en,
    input  fsf_lanes_e     lanes,
    input  logic [3:0]     bits,
    output logic           done,
    output logic [W-1:0]   byte_o
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

    logic [W-2:0]     sh;
    logic [CNT_W-1:0] cnt, cnt_n, step;
    logic [W-1:0]     nxt;

    always_comb begin
        unique case (lanes)
            LN_ONE:  begin nxt = {sh[W-2:0], bits[0]};   step = CNT_W'(1); end
            LN_TWO:  begin nxt = {sh[W-3:0], bits[1:0]}; step = CNT_W'(2); end
            LN_FOUR: begin nxt = {sh[W-5:0], bits};      step = CNT_W'(4); end
            default: begin nxt = '0;                     step = '0;        end
        endcase
        cnt_n  = cnt + step;
        done   = shift_en && (cnt_n == FULL);
        byte_o = nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh  <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            sh  <= nxt[W-2:0];
            cnt <= done ? '0 : cnt_n;
        end
    end
endmodule

// File: rtl/fsf_bus_monitor.sv
module fsf_bus_monitor
    import fsf_pkg::*;
#(
    parameter int         ADDR_BYTES     = 3,
    parameter int         DUMMY_CLKS     = 8,
    parameter int         QIO_DUMMY_CLKS = 4,
    parameter logic [3:0] CONT_NIBBLE    = 4'hA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sck,
    input  logic [3:0]  io,
    input  logic [7:0]  trig_op,
    input  logic [23:0] trig_addr,
    output logic        op_valid,
    output logic [7:0]  op_byte,
    output logic        addr_valid,
    output logic [23:0] addr,
    output logic        data_valid,
    output logic [7:0]  data_byte,
    output logic        trig_pulse,
    output logic        cont_active
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int AC_W   = $clog2(ADDR_BYTES);
    localparam int DC_MAX = (DUMMY_CLKS > QIO_DUMMY_CLKS) ? DUMMY_CLKS : QIO_DUMMY_CLKS;
    localparam int DC_W   = $clog2(DC_MAX + 1);
    localparam logic [AC_W-1:0] ADDR_LAST = AC_W'(ADDR_BYTES - 1);

    fsf_state_e       state, nxt_state;
    fsf_lanes_e       lanes;
    logic [3:0]       bits;
    logic             active, edge_en, shift_en, byte_done;
    logic [7:0]       byte_val;
    logic [7:0]       cur_op;
    logic             op_seen;
    logic [AC_W-1:0]  addr_cnt;
    logic [ADDR_W-9:0] addr_acc;
    logic [DC_W-1:0]  dummy_cnt;
    logic [ADDR_W-1:0] full_addr;

    assign active    = !cs_n;
    assign full_addr = {addr_acc, byte_val};

    fsf_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sck_rise (edge_en_raw)
    );
    logic edge_en_raw;
    assign edge_en = active && edge_en_raw;

    fsf_shift #(.W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!active),
        .shift_en (shift_en),
        .lanes    (lanes),
        .bits     (bits),
        .done     (byte_done),
        .byte_o   (byte_val)
    );

    // Lane selection per phase and command
    always_comb begin
        lanes    = LN_ONE;
        bits     = {3'b000, io[0]};
        shift_en = 1'b0;
        unique case (state)
            ST_CMD: shift_en = edge_en;
            ST_ADDR: begin
                shift_en = edge_en;
                if (cur_op == OP_QUAD_IO) begin
                    lanes = LN_FOUR;
                    bits  = io;
                end
            end
            ST_MODE: begin
                shift_en = edge_en;
                lanes    = LN_FOUR;
                bits     = io;
            end
            ST_DATA: begin
                shift_en = edge_en;
                if (cur_op == OP_FAST_SINGLE) begin
                    bits = {3'b000, io[1]};
                end else if (cur_op == OP_DUAL_OUT) begin
                    lanes = LN_TWO;
                    bits  = {2'b00, io[1:0]};
                end else begin
                    lanes = LN_FOUR;
                    bits  = io;
                end
            end
            ST_IDLE, ST_DUMMY, ST_SKIP: ;
        endcase
    end

    // Next-state logic
    always_comb begin
        nxt_state = state;
        if (!active) begin
            nxt_state = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt_state = cont_active ? ST_ADDR : ST_CMD;
                ST_CMD:   if (byte_done) nxt_state = is_read_op(byte_val) ? ST_ADDR : ST_SKIP;
                ST_ADDR:  if (byte_done && addr_cnt == ADDR_LAST)
                              nxt_state = (cur_op == OP_QUAD_IO) ? ST_MODE : ST_DUMMY;
                ST_MODE:  if (byte_done) nxt_state = ST_DUMMY;
                ST_DUMMY: if (edge_en && dummy_cnt == DC_W'(1)) nxt_state = ST_DATA;
                ST_DATA, ST_SKIP: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Outputs and per-transaction context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid    <= 1'b0;
            op_byte     <= '0;
            addr_valid  <= 1'b0;
            addr        <= '0;
            data_valid  <= 1'b0;
            data_byte   <= '0;
            trig_pulse  <= 1'b0;
            cont_active <= 1'b0;
            cur_op      <= '0;
            op_seen     <= 1'b0;
            addr_cnt    <= '0;
            addr_acc    <= '0;
            dummy_cnt   <= '0;
        end else begin
            op_valid   <= 1'b0;
            addr_valid <= 1'b0;
            data_valid <= 1'b0;
            trig_pulse <= 1'b0;

            if (state == ST_IDLE && active) begin
                addr_cnt <= '0;
                op_seen  <= !cont_active;
                cur_op   <= cont_active ? OP_QUAD_IO : 8'h00;
            end

            if (byte_done) begin
                unique case (state)
                    ST_CMD: begin
                        op_valid <= 1'b1;
                        op_byte  <= byte_val;
                        cur_op   <= byte_val;
                    end
                    ST_ADDR: begin
                        addr_acc <= {addr_acc[ADDR_W-17:0], byte_val};
                        addr_cnt <= addr_cnt + AC_W'(1);
                        if (addr_cnt == ADDR_LAST) begin
                            addr_valid <= 1'b1;
                            addr       <= full_addr;
                            trig_pulse <= op_seen && (cur_op == trig_op) &&
                                          (full_addr == trig_addr);
                        end
                    end
                    ST_MODE: cont_active <= (byte_val[7:4] == CONT_NIBBLE);
                    ST_DATA: begin
                        data_valid <= 1'b1;
                        data_byte  <= byte_val;
                    end
                    default: ;
                endcase
            end

            if (state == ST_ADDR && nxt_state == ST_DUMMY)
                dummy_cnt <= DC_W'(DUMMY_CLKS);
            else if (state == ST_MODE && byte_done)
                dummy_cnt <= DC_W'(QIO_DUMMY_CLKS);
            else if (state == ST_DUMMY && edge_en)
                dummy_cnt <= dummy_cnt - DC_W'(1);
        end
    end
endmodule

// File: rtl/fsf_bus_monitor_chk.sv
module fsf_bus_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic op_valid,
    input logic addr_valid,
    input logic data_valid,
    input logic trig_pulse,
    input logic cont_active
);
    logic cs_q;
    logic cont_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q       <= 1'b1;
            cont_start <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (cs_n)      cont_start <= 1'b0;
            else if (cs_q) cont_start <= cont_active;
        end
    end

    a_r11_op_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> !op_valid);
    a_r11_data_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);
    a_r8_trig_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> addr_valid);
    a_r8_trig_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> !cont_start);
    a_r7_cont_no_op: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !cont_start);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !(op_valid || addr_valid || data_valid));
    a_r6_cont_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> $stable(cont_active));
endmodule

bind fsf_bus_monitor fsf_bus_monitor_chk chk_i (.*);

// File: tb/fsf_bus_monitor_tb_top.sv
module fsf_bus_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic [3:0]  io = 4'h0;
    logic [7:0]  trig_op = 8'h0B;
    logic [23:0] trig_addr = 24'h122345;
    logic        op_valid, addr_valid, data_valid, trig_pulse, cont_active;
    logic [7:0]  op_byte, data_byte;
    logic [23:0] addr;

    always #5 clk = ~clk;

    fsf_bus_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .io(io),
        .trig_op(trig_op), .trig_addr(trig_addr),
        .op_valid(op_valid), .op_byte(op_byte),
        .addr_valid(addr_valid), .addr(addr),
        .data_valid(data_valid), .data_byte(data_byte),
        .trig_pulse(trig_pulse), .cont_active(cont_active)
    );

    int n_checks = 0;
    int n_fail = 0;

    // Strobe monitor, sampled away from the active edge
    int          m_op_n, m_addr_n, m_data_n, m_trig_n, m_trig_co;
    logic [7:0]  m_op;
    logic [23:0] m_addr;
    logic [7:0]  m_data [4];

    always @(negedge clk) begin
        if (rst_n) begin
            if (op_valid)   begin m_op_n++; m_op = op_byte; end
            if (addr_valid) begin m_addr_n++; m_addr = addr; end
            if (data_valid) begin
                if (m_data_n < 4) m_data[m_data_n] = data_byte;
                m_data_n++;
            end
            if (trig_pulse) m_trig_n++;
            if (trig_pulse && addr_valid) m_trig_co++;
        end
    end

    task automatic mon_clear();
        m_op_n = 0; m_addr_n = 0; m_data_n = 0; m_trig_n = 0; m_trig_co = 0;
        m_op = '0; m_addr = '0;
        for (int i = 0; i < 4; i++) m_data[i] = '0;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bit_clk(input logic [3:0] v);
        @(negedge clk); io = v; sck = 1'b0;
        @(negedge clk);
        @(negedge clk); sck = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int nl, input int dl);
        if (nl == 1) begin
            for (int i = 7; i >= 0; i--) begin
                logic [3:0] v;
                v = 4'h0; v[dl] = b[i];
                bit_clk(v);
            end
        end else if (nl == 2) begin
            for (int k = 3; k >= 0; k--) bit_clk({2'b00, b[2*k+1], b[2*k]});
        end else begin
            bit_clk(b[7:4]);
            bit_clk(b[3:0]);
        end
    endtask

    task automatic cs_begin();
        mon_clear();
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cs_end();
        @(negedge clk); sck = 1'b0;
        @(negedge clk); cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_txn(input logic [7:0] op, input bit send_op, input logic [23:0] a,
                           input logic [7:0] mode, input logic [7:0] d0, input logic [7:0] d1);
        int al, dl_n, dlane;
        al    = (op == 8'hEB) ? 4 : 1;
        dl_n  = (op == 8'h0B) ? 1 : (op == 8'h3B) ? 2 : 4;
        dlane = (op == 8'h0B) ? 1 : 0;
        cs_begin();
        if (send_op) send_byte(op, 1, 0);
        send_byte(a[23:16], al, 0);
        send_byte(a[15:8],  al, 0);
        send_byte(a[7:0],   al, 0);
        if (op == 8'hEB) begin
            send_byte(mode, 4, 0);
            repeat (4) bit_clk(4'hF);
        end else begin
            repeat (8) bit_clk(4'hF);
        end
        send_byte(d0, dl_n, dlane);
        send_byte(d1, dl_n, dlane);
        cs_end();
    endtask

    // {opcode, address, mode byte, data0, data1}
    localparam logic [55:0] VEC [5] = '{
        {8'h0B, 24'h122345, 8'h00, 8'hA5, 8'h3C},
        {8'h3B, 24'h00A00F, 8'h00, 8'h5A, 8'hC3},
        {8'h6B, 24'hFFFFFF, 8'h00, 8'h96, 8'h0F},
        {8'hEB, 24'h010203, 8'h5A, 8'h3C, 8'hA5},
        {8'h0B, 24'h122346, 8'h00, 8'h81, 8'h7E}
    };

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual hung expected done");
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        join_none

        mon_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({op_valid, addr_valid, data_valid, trig_pulse, cont_active} == 5'b0,
              "R1 reset outputs", {27'b0, op_valid, addr_valid, data_valid, trig_pulse, cont_active}, 0);

        for (int i = 0; i < 5; i++) begin
            logic [7:0]  op, md, d0, d1;
            logic [23:0] a;
            bit          exp_trig;
            {op, a, md, d0, d1} = VEC[i];
            exp_trig = (op == trig_op) && (a == trig_addr);
            run_txn(op, 1'b1, a, md, d0, d1);
            check(m_op_n == 1 && m_op == op, "R2 opcode", {24'b0, m_op}, {24'b0, op});
            check(m_addr_n == 1 && m_addr == a, "R3 address", {8'b0, m_addr}, {8'b0, a});
            check(m_data_n == 2, "R5 R11 data count, dummies skipped", m_data_n, 2);
            check(m_data[0] == d0 && m_data[1] == d1, "R4 data bytes",
                  {16'b0, m_data[0], m_data[1]}, {16'b0, d0, d1});
            check(m_trig_n == int'(exp_trig), "R8 trigger count", m_trig_n, exp_trig);
            check(m_trig_co == int'(exp_trig), "R8 trigger with address", m_trig_co, exp_trig);
            check(cont_active == 1'b0, "R6 mode not entered", cont_active, 0);
        end

        // R6 enter continuous mode
        run_txn(8'hEB, 1'b1, 24'h0A0B0C, 8'hA5, 8'h11, 8'h22);
        check(cont_active == 1'b1, "R6 mode entered", cont_active, 1);
        check(m_data[0] == 8'h11 && m_data[1] == 8'h22, "R5 quad dummies skipped",
              {16'b0, m_data[0], m_data[1]}, 32'h1122);

        // R7 address-first transaction, R8 no trigger without opcode
        trig_op = 8'hEB; trig_addr = 24'h0A0B0C;
        run_txn(8'hEB, 1'b0, 24'h0A0B0C, 8'h20, 8'h33, 8'h44);
        check(m_op_n == 0, "R7 no opcode strobe", m_op_n, 0);
        check(m_addr_n == 1 && m_addr == 24'h0A0B0C, "R7 address first",
              {8'b0, m_addr}, 32'h0A0B0C);
        check(m_data[0] == 8'h33 && m_data[1] == 8'h44, "R7 data",
              {16'b0, m_data[0], m_data[1]}, 32'h3344);
        check(m_trig_n == 0, "R8 no trigger without opcode", m_trig_n, 0);
        check(cont_active == 1'b0, "R6 mode left", cont_active, 0);

        // R9 abort mid-address
        cs_begin();
        send_byte(8'h0B, 1, 0);
        for (int i = 0; i < 4; i++) bit_clk(4'h1);
        cs_end();
        check(m_op_n == 1 && m_addr_n == 0, "R9 aborted address dropped", m_addr_n, 0);
        run_txn(8'h6B, 1'b1, 24'h7E8181, 8'h00, 8'h12, 8'h34);
        check(m_addr == 24'h7E8181, "R9 clean restart address", {8'b0, m_addr}, 32'h7E8181);
        check(m_data[0] == 8'h12 && m_data[1] == 8'h34, "R9 clean restart data",
              {16'b0, m_data[0], m_data[1]}, 32'h1234);

        // R10 unknown command
        run_txn(8'h9F, 1'b1, 24'h123456, 8'h00, 8'hAB, 8'hCD);
        check(m_op_n == 1 && m_op == 8'h9F, "R10 unknown opcode reported", {24'b0, m_op}, 32'h9F);
        check(m_addr_n == 0 && m_data_n == 0, "R10 rest ignored", m_addr_n + m_data_n, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule